// File: doc/BRIEF.md
# Descriptor-Ring I2C Master Engine

This block runs a queue of I2C master transfers without processor help once started. Software builds transmit and receive descriptors in a word memory and sets their ownership bits. It then enables the engine and issues a start command. The engine walks the transmit ring in order. It sends each descriptor's bytes through a byte-level link interface, which handles START, byte write, byte read, STOP and the acknowledge result. Completion and error status are written back into the descriptors.

A descriptor takes three consecutive memory words: a status word, a byte count and a buffer pointer. Descriptor i of a ring sits at the ring base plus 3*i. Each buffer byte is held in the low 8 bits of one memory word. A read is written as a transmit descriptor. Its first byte is the device address shifted left with bit 0 set, and it is followed by one placeholder byte for each byte wanted. The bytes clocked in for those placeholders land in the current receive descriptor's buffer.

Top module: `i2c_bd_engine`

## Requirements
- R1: A run starts only when bit 0 of the mode register (reg_addr 0) is 1 and a write to the command register (reg_addr 1) has bit 7 set. Every run reloads both ring pointers from the base registers (reg_addr 2 for transmit, reg_addr 3 for receive). While idle, the engine drives neither the memory port nor the link.
- R2: A transmit descriptor with status bit 0x0400 gets a link START (lk_cmd 0) before its first byte. A descriptor without that bit continues the open transfer, and no START is issued for it. Written bytes use lk_cmd 1.
- R3: In status, 0x8000 marks a transmit descriptor as ready. The engine clears that bit when it writes the status back and keeps the other bits. A descriptor with 0x0800 (last) is followed by a STOP (lk_cmd 3), and the run ends there.
- R4: After a descriptor whose status has 0x2000 (wrap), or after the fourth descriptor, the ring pointer returns to the ring base.
- R5: A descriptor that carries 0x0400, has a length above 1 and has a first byte with bit 0 set is a read. Its remaining length-1 positions become READ commands (lk_cmd 2). The read bytes are stored in order into the receive descriptor's buffer, and that descriptor's 0x8000 (empty) bit is cleared.
- R6: In a read, every received byte is acknowledged (lk_ack 1) except the final one, which gets lk_ack 0.
- R7: The maximum-receive-length register (reg_addr 4, reset value 128) and the receive descriptor's own length both cap the number of bytes stored. Bytes beyond the cap are not written, and they set 0x0002 (overrun) in the receive status.
- R8: A NAK on a written byte sets 0x0004 in that descriptor's status and clears its ready bit. The engine then issues STOP and ends the run. Later descriptors are not touched.
- R9: A collision reported on any START, write or read sets 0x0001 in the current descriptor and ends the run with no STOP.
- R10: A ready transmit descriptor with length 0 gets 0x0002 (underflow) with ready cleared. The run ends, with a STOP if a transfer is open.
- R11: A transmit descriptor found without its ready bit ends the run, with a STOP if a transfer is open. The descriptor is left unchanged.
- R12: done goes to 1 when a run ends and stays there until a write to reg_addr 5 with bit 0 set. busy is 1 while a run is in progress.
- R13: lk_valid is a one-cycle pulse. No new command is issued until lk_done answers the previous one.
- R14: After reset, done, busy, lk_valid and mem_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky end-of-run flag |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |
| lk_valid | output | 1 | Link command pulse |
| lk_cmd | output | 2 | 0 START, 1 write, 2 read, 3 STOP |
| lk_wdata | output | 8 | Byte to write |
| lk_ack | output | 1 | Acknowledge to send for a read byte |
| lk_done | input | 1 | Link command finished |
| lk_nak | input | 1 | Written byte was not acknowledged |
| lk_col | input | 1 | Collision during the command |
| lk_rdata | input | 8 | Byte read from the bus |

## Verification
A wrong byte counter or ring pointer shows at the link within one command. The trace gets extra or missing writes, reads or STOPs, or the ack on the final read is wrong. A bad pointer also leaves descriptor words changed or unchanged where they should not be, and this can be seen as soon as the run ends. A stuck sequencer shows up as done never rising. An error path that ignores its flag leaves the ready bit set or lets commands go on after the NAK or collision.

// File: rtl/i2c_bd_engine.sv
module i2c_bd_engine #(
  parameter int AW      = 16,
  parameter int NDESC   = 4,
  parameter int MRL_RST = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          lk_valid,
  output logic [1:0]    lk_cmd,
  output logic [7:0]    lk_wdata,
  output logic          lk_ack,
  input  logic          lk_done,
  input  logic          lk_nak,
  input  logic          lk_col,
  input  logic [7:0]    lk_rdata
);
  localparam int IW = (NDESC > 1) ? $clog2(NDESC) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NDESC - 1);
  localparam int B_OWN = 15, B_WRAP = 13, B_LAST = 11, B_START = 10;
  localparam logic [2:0] E_CL = 3'b001, E_UN = 3'b010, E_NAK = 3'b100;
  localparam logic [15:0] RX_OV = 16'h0002;
  localparam logic [1:0] C_START = 2'd0, C_WR = 2'd1, C_RD = 2'd2, C_STOP = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_FST, S_FLEN, S_FPTR, S_FEND, S_BRD, S_BSEND,
    S_LISS, S_LWAIT, S_RXWR, S_RXWB, S_WB, S_FIN
  } state_t;

  state_t st;
  logic          mode_en, fx, open, ov, ack_r;
  logic [AW-1:0] tx_base, rx_base, tp, rp, tptr, rptr;
  logic [IW-1:0] ti, ri;
  logic [15:0]   mrl, tst, tlen, rst_s, rlen, k;
  logic [2:0]    err;
  logic [1:0]    cmd;
  logic [7:0]    wbyte, rbyte;

  wire           go       = reg_we && reg_addr == 3'd1 && reg_wdata[7] && mode_en && st == S_IDLE;
  wire           done_clr = reg_we && reg_addr == 3'd5 && reg_wdata[0];
  wire [AW-1:0]  fbase    = fx ? rp : tp;
  wire [15:0]    j        = k - 16'd1;
  wire           store_ok = (j < rlen) && (j < mrl);
  wire           last_pos = (k == tlen - 16'd1);

  assign busy     = (st != S_IDLE);
  assign lk_valid = (st == S_LISS);
  assign lk_cmd   = cmd;
  assign lk_wdata = wbyte;
  assign lk_ack   = ack_r;

  always_comb begin
    mem_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st)
      S_FST:  begin mem_en = 1'b1; mem_addr = fbase; end
      S_FLEN: begin mem_en = 1'b1; mem_addr = fbase + AW'(1); end
      S_FPTR: begin mem_en = 1'b1; mem_addr = fbase + AW'(2); end
      S_BRD:  begin mem_en = 1'b1; mem_addr = tptr + k[AW-1:0]; end
      S_RXWR: if (store_ok) begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = rptr + j[AW-1:0]; mem_wdata = {8'h00, rbyte};
      end
      S_RXWB: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = rp;
        mem_wdata = (rst_s & ~16'h8000) | (ov ? RX_OV : 16'h0000);
      end
      S_WB: begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = tp;
        mem_wdata = (tst & ~16'h8000) | {13'd0, err};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_en <= 1'b0; done <= 1'b0; mrl <= 16'(MRL_RST);
      tx_base <= '0; rx_base <= '0; tp <= '0; rp <= '0; tptr <= '0; rptr <= '0;
      ti <= '0; ri <= '0; fx <= 1'b0; open <= 1'b0; ov <= 1'b0; ack_r <= 1'b0;
      tst <= '0; tlen <= '0; rst_s <= '0; rlen <= '0; k <= '0; err <= '0;
      cmd <= C_START; wbyte <= '0; rbyte <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: mode_en <= reg_wdata[0];
          3'd2: tx_base <= reg_wdata[AW-1:0];
          3'd3: rx_base <= reg_wdata[AW-1:0];
          3'd4: mrl     <= reg_wdata;
          default: ;
        endcase
      end
      if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          tp <= tx_base; rp <= rx_base; ti <= '0; ri <= '0;
          open <= 1'b0; fx <= 1'b0; st <= S_FST;
        end
        S_FST:  st <= S_FLEN;
        S_FLEN: begin
          if (fx) rst_s <= mem_rdata; else tst <= mem_rdata;
          st <= S_FPTR;
        end
        S_FPTR: begin
          if (fx) rlen <= mem_rdata; else tlen <= mem_rdata;
          st <= S_FEND;
        end
        S_FEND: if (fx) begin
          rptr <= mem_rdata[AW-1:0]; ov <= 1'b0;
          cmd <= C_RD; ack_r <= !last_pos; st <= S_LISS;
        end else begin
          tptr <= mem_rdata[AW-1:0]; err <= '0; k <= '0;
          if (!tst[B_OWN]) begin
            if (open) begin cmd <= C_STOP; st <= S_LISS; end
            else st <= S_FIN;
          end else if (tlen == 16'd0) begin
            err <= E_UN; st <= S_WB;
          end else if (tst[B_START]) begin
            cmd <= C_START; open <= 1'b1; st <= S_LISS;
          end else st <= S_BRD;
        end
        S_BRD:   st <= S_BSEND;
        S_BSEND: begin wbyte <= mem_rdata[7:0]; cmd <= C_WR; st <= S_LISS; end
        S_LISS:  st <= S_LWAIT;
        S_LWAIT: if (lk_done) begin
          if (cmd == C_STOP) begin
            open <= 1'b0; st <= S_FIN;
          end else if (lk_col) begin
            err <= E_CL; open <= 1'b0; st <= S_WB;
          end else if (cmd == C_START) begin
            st <= S_BRD;
          end else if (cmd == C_WR) begin
            if (lk_nak) begin
              err <= E_NAK; st <= S_WB;
            end else if (k == 16'd0 && tst[B_START] && wbyte[0] && tlen > 16'd1) begin
              k <= 16'd1; fx <= 1'b1; st <= S_FST;
            end else if (last_pos) begin
              st <= S_WB;
            end else begin
              k <= k + 16'd1; st <= S_BRD;
            end
          end else begin
            rbyte <= lk_rdata; st <= S_RXWR;
          end
        end
        S_RXWR: begin
          if (!store_ok) ov <= 1'b1;
          if (last_pos) st <= S_RXWB;
          else begin
            k <= k + 16'd1; ack_r <= (k + 16'd1 != tlen - 16'd1);
            cmd <= C_RD; st <= S_LISS;
          end
        end
        S_RXWB: begin
          if (rst_s[B_WRAP] || ri == LAST_IDX) begin rp <= rx_base; ri <= '0; end
          else begin rp <= rp + AW'(3); ri <= ri + 1'b1; end
          fx <= 1'b0; st <= S_WB;
        end
        S_WB: begin
          if (err != 3'd0 || tst[B_LAST]) begin
            if (open) begin cmd <= C_STOP; st <= S_LISS; end
            else st <= S_FIN;
          end else begin
            if (tst[B_WRAP] || ti == LAST_IDX) begin tp <= tx_base; ti <= '0; end
            else begin tp <= tp + AW'(3); ti <= ti + 1'b1; end
            st <= S_FST;
          end
        end
        S_FIN: begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PULSE_CMD: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> !lk_valid); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!mem_en && !lk_valid)); // R1
  AST_START_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(mode_en)); // R1
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !done_clr) |=> done); // R12
  AST_STOP_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_cmd == C_STOP) |-> open); // R3
  AST_READ_OPEN: assert property (@(posedge clk) disable iff (!rst_n) (lk_valid && lk_cmd == C_RD) |-> open); // R5
endmodule

// File: tb/sim_i2c_bd_engine.sv
`timescale 1ns/1ps
module sim_i2c_bd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [15:0] reg_wdata = '0;
  logic busy, done, mem_en, mem_we, lk_valid, lk_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] lk_cmd; logic [7:0] lk_wdata;
  logic lk_done = 1'b0, lk_nak = 1'b0, lk_col = 1'b0; logic [7:0] lk_rdata = '0;

  i2c_bd_engine u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .busy, .done,
    .mem_en, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .lk_valid, .lk_cmd,
    .lk_wdata, .lk_ack, .lk_done, .lk_nak, .lk_col, .lk_rdata);

  logic [15:0] mem [0:255];
  logic bw_en = 1'b0; logic [7:0] bw_a = '0; logic [15:0] bw_d = '0;
  always @(posedge clk) begin
    if (bw_en) mem[bw_a] <= bw_d;
    else if (mem_en && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  logic tb_clr = 1'b1;
  int ntr, wcnt, rcnt, cd, nak_w = -1, col_c = -1;
  logic ovl, p_nak, p_col; logic [7:0] p_dat;
  logic [1:0] tr_cmd [0:63]; logic [7:0] tr_dat [0:63]; logic tr_ack [0:63];
  always @(posedge clk) begin
    lk_done <= 1'b0;
    if (tb_clr) begin
      ntr <= 0; wcnt <= 0; rcnt <= 0; cd <= 0; ovl <= 1'b0;
    end else if (lk_valid) begin
      if (cd != 0) ovl <= 1'b1;
      if (ntr < 64) begin tr_cmd[ntr] <= lk_cmd; tr_dat[ntr] <= lk_wdata; tr_ack[ntr] <= lk_ack; end
      ntr <= ntr + 1;
      p_nak <= (lk_cmd == 2'd1) && (wcnt == nak_w);
      p_col <= (ntr == col_c);
      p_dat <= 8'h50 + rcnt[7:0];
      if (lk_cmd == 2'd1) wcnt <= wcnt + 1;
      if (lk_cmd == 2'd2) rcnt <= rcnt + 1;
      cd <= 2;
    end else if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) begin lk_done <= 1'b1; lk_nak <= p_nak; lk_col <= p_col; lk_rdata <= p_dat; end
    end
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic poke(input logic [7:0] a, input logic [15:0] d);
    bw_en = 1'b1; bw_a = a; bw_d = d; @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic desc(input logic [7:0] a, input logic [15:0] s, input logic [15:0] l, input logic [15:0] p);
    poke(a, s); poke(a + 8'd1, l); poke(a + 8'd2, p);
  endtask

  task automatic wipe();
    for (int i = 0; i < 192; i++) poke(8'(i), 16'h0000);
    nak_w = -1; col_c = -1;
  endtask

  task automatic run(input logic en);
    @(negedge clk); tb_clr = 1'b1; @(negedge clk); tb_clr = 1'b0;
    reg_wr(3'd0, {15'd0, en}); reg_wr(3'd2, 16'h0000); reg_wr(3'd3, 16'h0020);
    reg_wr(3'd1, 16'h0080);
    if (en) begin
      for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
      chk(done === 1'b1, "R12 run end", done, 1);
      chk(ovl === 1'b0, "R13 overlap", ovl, 0);
      reg_wr(3'd5, 16'h0001);
    end
  endtask

  // dev, length incl. address, nak write index (FF none), final status, link command count
  localparam logic [47:0] VEC [0:4] = '{
    {8'h50, 8'd3, 8'hFF, 16'h0C00, 8'd5},
    {8'h51, 8'd1, 8'hFF, 16'h0C00, 8'd3},
    {8'h52, 8'd4, 8'h00, 16'h0C04, 8'd3},
    {8'h53, 8'd4, 8'h02, 16'h0C04, 8'd5},
    {8'h54, 8'd6, 8'hFF, 16'h0C00, 8'd8}
  };

  initial begin
    #(4 * 200000);
    nfail++; $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R14 done/busy", {done, busy}, 0);
    chk(lk_valid === 1'b0 && mem_en === 1'b0, "R14 valid/mem", {lk_valid, mem_en}, 0);

    for (int v = 0; v < 5; v++) begin
      logic [7:0] dv, ln, nk, nc; logic [15:0] es;
      {dv, ln, nk, es, nc} = VEC[v];
      wipe();
      desc(8'h00, 16'h8C00, {8'd0, ln}, 16'h0040);
      poke(8'h40, {8'd0, dv[6:0], 1'b0});
      for (int i = 1; i < 8; i++) poke(8'(8'h40 + i), 16'(8'h10 + i));
      nak_w = (nk == 8'hFF) ? -1 : int'(nk);
      run(1'b1);
      chk(mem[0] == es, "R3/R8 status", mem[0], es);
      chk(ntr == int'(nc), "R3 command count", ntr, nc);
      chk(tr_cmd[0] == 2'd0 && tr_dat[1] == {dv[6:0], 1'b0}, "R2 start+addr", tr_dat[1], {dv[6:0], 1'b0});
      chk(tr_cmd[ntr-1] == 2'd3, "R3 stop", tr_cmd[ntr-1], 3);
    end

    // R1: disabled engine ignores the start command
    wipe(); desc(8'h00, 16'h8C00, 16'd1, 16'h0040); poke(8'h40, 16'h00A0);
    run(1'b0);
    repeat (30) @(negedge clk);
    chk(busy === 1'b0 && ntr == 0, "R1 gated", ntr, 0);
    chk(mem[0] == 16'h8C00, "R1 untouched", mem[0], 16'h8C00);
    run(1'b1);
    chk(ntr == 3 && mem[0] == 16'h0C00, "R1 enabled run", ntr, 3);

    // R2: chained descriptors, one START
    wipe();
    desc(8'h00, 16'h8400, 16'd2, 16'h0040); desc(8'h03, 16'h8800, 16'd2, 16'h0050);
    poke(8'h40, 16'h00A0); poke(8'h41, 16'h0010); poke(8'h50, 16'h0055); poke(8'h51, 16'h0066);
    run(1'b1);
    chk(ntr == 6 && tr_cmd[3] == 2'd1 && tr_dat[3] == 8'h55, "R2 chain", tr_dat[3], 8'h55);
    chk(mem[0] == 16'h0400 && mem[3] == 16'h0800, "R3 chain status", {mem[0], mem[3]}, 32'h04000800);

    // R5/R6: simple read of 3 bytes
    wipe();
    desc(8'h00, 16'h8C00, 16'd4, 16'h0040); poke(8'h40, 16'h0043);
    desc(8'h20, 16'h8000, 16'd3, 16'h0080);
    run(1'b1);
    chk(ntr == 6 && tr_cmd[2] == 2'd2 && tr_cmd[4] == 2'd2, "R5 read cmds", ntr, 6);
    chk(tr_ack[2] && tr_ack[3] && !tr_ack[4], "R6 ack pattern", {tr_ack[2], tr_ack[3], tr_ack[4]}, 3'b110);
    chk(mem[8'h80] == 16'h50 && mem[8'h82] == 16'h52, "R5 data", mem[8'h82], 16'h52);
    chk(mem[8'h20] == 16'h0000 && mem[0] == 16'h0C00, "R5 status", mem[8'h20], 0);

    // R2/R5: address write then repeated START read
    wipe();
    desc(8'h00, 16'h8400, 16'd2, 16'h0040); poke(8'h40, 16'h00A0); poke(8'h41, 16'h0005);
    desc(8'h03, 16'h8C00, 16'd3, 16'h0050); poke(8'h50, 16'h00A1);
    desc(8'h20, 16'h8000, 16'd2, 16'h0080);
    run(1'b1);
    chk(ntr == 8 && tr_cmd[3] == 2'd0 && tr_dat[4] == 8'hA1, "R2 repeated start", ntr, 8);
    chk(mem[8'h81] == 16'h51 && !tr_ack[6], "R5/R6 combined", mem[8'h81], 16'h51);

    // R7: cap by maximum receive length
    wipe();
    desc(8'h00, 16'h8C00, 16'd4, 16'h0040); poke(8'h40, 16'h0043);
    desc(8'h20, 16'h8000, 16'd3, 16'h0080); poke(8'h82, 16'hEEEE);
    reg_wr(3'd4, 16'd2);
    run(1'b1);
    reg_wr(3'd4, 16'd128);
    chk(mem[8'h20] == 16'h0002, "R7 overrun flag", mem[8'h20], 16'h0002);
    chk(mem[8'h81] == 16'h51 && mem[8'h82] == 16'hEEEE, "R7 capped store", mem[8'h82], 16'hEEEE);

    // R8: NAK halts, later descriptor untouched
    wipe();
    desc(8'h00, 16'h8400, 16'd2, 16'h0040); poke(8'h40, 16'h00A0); poke(8'h41, 16'h0011);
    desc(8'h03, 16'h8800, 16'd1, 16'h0050);
    nak_w = 1;
    run(1'b1);
    chk(mem[0] == 16'h0404 && mem[3] == 16'h8800, "R8 nak halt", mem[3], 16'h8800);
    chk(ntr == 4 && tr_cmd[3] == 2'd3, "R8 stop after nak", ntr, 4);

    // R9: collision, no STOP
    wipe();
    desc(8'h00, 16'h8C00, 16'd3, 16'h0040); poke(8'h40, 16'h00A0);
    col_c = 1;
    run(1'b1);
    chk(mem[0] == 16'h0C01, "R9 collision status", mem[0], 16'h0C01);
    chk(ntr == 2 && tr_cmd[1] == 2'd1, "R9 no stop", ntr, 2);

    // R10: zero-length descriptor mid-transfer
    wipe();
    desc(8'h00, 16'h8400, 16'd1, 16'h0040); poke(8'h40, 16'h00A0);
    desc(8'h03, 16'h8800, 16'd0, 16'h0050);
    run(1'b1);
    chk(mem[3] == 16'h0802, "R10 underflow", mem[3], 16'h0802);
    chk(ntr == 3 && tr_cmd[2] == 2'd3, "R10 stop", ntr, 3);

    // R11: unowned descriptor ends the run
    wipe();
    desc(8'h00, 16'h8400, 16'd1, 16'h0040); poke(8'h40, 16'h00A0);
    desc(8'h03, 16'h0000, 16'd7, 16'h0050);
    run(1'b1);
    chk(mem[3] == 16'h0000 && mem[4] == 16'd7, "R11 untouched", mem[4], 7);
    chk(ntr == 3 && tr_cmd[2] == 2'd3, "R11 stop", ntr, 3);

    // R4: wrap flag
    wipe();
    desc(8'h00, 16'hA400, 16'd1, 16'h0040); poke(8'h40, 16'h00A0);
    desc(8'h03, 16'h8C00, 16'd1, 16'h0050);
    run(1'b1);
    chk(ntr == 3 && mem[3] == 16'h8C00, "R4 wrap flag", mem[3], 16'h8C00);
    // R4: natural wrap after the fourth descriptor
    wipe();
    desc(8'h00, 16'h8400, 16'd1, 16'h0040); desc(8'h03, 16'h8000, 16'd1, 16'h0041);
    desc(8'h06, 16'h8000, 16'd1, 16'h0042); desc(8'h09, 16'h8000, 16'd1, 16'h0043);
    desc(8'h0C, 16'h8800, 16'd1, 16'h0044);
    run(1'b1);
    chk(ntr == 6 && mem[9] == 16'h0000, "R4 ring wrap", ntr, 6);
    chk(mem[8'h0C] == 16'h8800, "R4 fifth slot unused", mem[8'h0C], 16'h8800);

    // R12: sticky done, write-one-to-clear
    wipe();
    desc(8'h00, 16'h8C00, 16'd1, 16'h0040);
    @(negedge clk); tb_clr = 1'b1; @(negedge clk); tb_clr = 1'b0;
    reg_wr(3'd0, 16'd1); reg_wr(3'd1, 16'h0080);
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    reg_wr(3'd5, 16'h0000); repeat (3) @(negedge clk);
    chk(done === 1'b1, "R12 sticky", done, 1);
    reg_wr(3'd5, 16'h0001);
    chk(done === 1'b0 && busy === 1'b0, "R12 cleared", done, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule